// File: doc/BRIEF.md
# Chainable Four-Channel Reload Timer Bank

This block holds four 16-bit timers that count upward, each behind a small 16-bit register bus. A channel takes its count steps either from a divided system clock or, in chain mode, from the overflow events of the channel with the next lower index. When a channel passes 0xFFFF it reloads from its own reload register. It emits a one-cycle overflow strobe on that cycle, and it can also emit a one-cycle interrupt pulse.

The bus has an asymmetry that software must respect. A write to a channel's count address only updates the reload value. A read of the same address returns the live count. The running count can only be set by a reload, and a reload happens on overflow and on each 0-to-1 change of the run bit. To pause a chained channel without a reload, software leaves it enabled and stops the channel below it.

Top module: `quad_reload_timer`

## Requirements
- R1: After reset every count, reload value and control field is 0, and ovf_o and irq_o are low.
- R2: A read of a count address returns the live count. A read of a control address returns the tick-select field in bits 2:0, the interrupt enable in bit 6 and the run bit in bit 7, and every other bit reads as 0.
- R3: A write to a count address stores the reload value and leaves the running count unchanged.
- R4: A write that changes the run bit (control bit 7) from 0 to 1 loads the count from the reload value at that clock edge.
- R5: With tick-select code 0 a running channel adds 1 to its count on every clock.
- R6: Tick-select codes 1, 2 and 3 advance the count once every 64, 256 and 1024 clocks. The divider restarts on enable, so the first step lands exactly one full period after the enabling edge.
- R7: When a step takes the count past 0xFFFF, the count reloads from the reload value, and ovf_o[n] is high for that single cycle.
- R8: When control bit 6 is set, irq_o[n] pulses together with the overflow strobe. When bit 6 is clear, irq_o[n] stays low.
- R9: Tick-select codes 4 to 7 select chain mode, in which channel n steps once for each overflow of channel n-1. Channel 0 never steps in chain mode.
- R10: A channel that is not running keeps its count and produces no overflow. A running channel in chain mode whose lower neighbour is stopped also keeps its count, and restarting the neighbour causes no reload of it.
- R11: Channel n is decoded at byte offset 0x100+4n for its count/reload and at 0x102+4n for its control. Odd or unmapped offsets read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 9 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| ovf_o | output | 4 | One-cycle overflow strobe per channel |
| irq_o | output | 4 | One-cycle interrupt pulse per channel |

## Verification
On every cycle the assertions check several rules. A stopped channel and a chained channel with a quiet neighbour hold their counts. Each non-wrapping step adds exactly one. Overflows and enable edges load the reload value. Divided ticks never come back to back, channel 0 stays silent in chain mode, and one access never writes two registers at once. Only the bench scenarios can show the rest. That covers the exact 64, 256 and 1024 clock distances to the first step, the read-back masking of control bits, and the reload-only effect of count writes as seen through the bus. It also covers chain counting across channels and the absence of a reload when a held chain resumes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BUS_W = 16;

  typedef enum logic [2:0] {
    SRC_CLK1    = 3'd0,
    SRC_DIV64   = 3'd1,
    SRC_DIV256  = 3'd2,
    SRC_DIV1024 = 3'd3,
    SRC_CHAIN   = 3'd4
  } tick_src_e;

  typedef struct packed {
    logic       run;
    logic       irq_en;
    logic [2:0] src;
  } tmr_ctrl_t;

  // codes 4..7 all select chain mode
  function automatic logic src_is_chain(input logic [2:0] s);
    return s[2];
  endfunction

  // log2 of the clock divider for the low two select bits
  function automatic int unsigned src_div_log2(input logic [1:0] s);
    case (s)
      2'd0:    return 0;
      2'd1:    return 6;
      2'd2:    return 8;
      default: return 10;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] ctrl_to_bus(input tmr_ctrl_t c);
    logic [BUS_W-1:0] d;
    d    = '0;
    d[7] = c.run;
    d[6] = c.irq_en;
    d[2:0] = c.src;
    return d;
  endfunction

  function automatic tmr_ctrl_t bus_to_ctrl(input logic [BUS_W-1:0] d);
    tmr_ctrl_t c;
    c.run    = d[7];
    c.irq_en = d[6];
    c.src    = d[2:0];
    return c;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate_sel,
  output logic       tick
);
  import tmr_pkg::*;

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] mask;

  // phase stays at zero while stopped, so it restarts on every enable
  always_ff @(posedge clk) begin
    if (!rst_n)    phase_q <= '0;
    else if (!run) phase_q <= '0;
    else           phase_q <= phase_q + 1'b1;
  end

  always_comb begin
    mask = (PRE_W'(1) << src_div_log2(rate_sel)) - PRE_W'(1);
    tick = run && ((phase_q & mask) == mask);
  end

  assert_div_tick_spaced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate_sel != 2'd0) |=> (!tick || rate_sel == 2'd0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctrl_we,
  input  logic                      reload_we,
  input  logic [tmr_pkg::BUS_W-1:0] wdata,
  input  logic                      chain_in,
  output logic [CNT_W-1:0]          count_o,
  output tmr_pkg::tmr_ctrl_t        ctrl_o,
  output logic                      ovf_o,
  output logic                      irq_o
);
  import tmr_pkg::*;

  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  logic             pre_tick;
  logic             run_rise;
  logic             step;
  logic             wrap;

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q.run),
    .rate_sel (ctrl_q.src[1:0]),
    .tick     (pre_tick)
  );

  always_comb begin
    run_rise = ctrl_we && wdata[7] && !ctrl_q.run;
    step     = ctrl_q.run && (src_is_chain(ctrl_q.src) ? chain_in : pre_tick);
    wrap     = step && (count_q == '1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (ctrl_we)   ctrl_q   <= bus_to_ctrl(wdata);
      if (reload_we) reload_q <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        count_q <= '0;
    else if (run_rise) count_q <= reload_q;
    else if (wrap)     count_q <= reload_q;
    else if (step)     count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;
  assign ctrl_o  = ctrl_q;
  assign ovf_o   = wrap;
  assign irq_o   = wrap && ctrl_q.irq_en;

  assert_hold_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !(ctrl_we && wdata[7])) |=> $stable(count_q));

  assert_reload_on_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.run) |-> (count_q == $past(reload_q)));

  assert_reload_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count_q == $past(reload_q)));

  assert_step_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wrap) |=> (count_q == $past(count_q) + 1'b1));

  assert_no_wrap_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.run |-> !ovf_o);
endmodule

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode #(
  parameter int unsigned         N_TMR  = 4,
  parameter int unsigned         ADDR_W = 9,
  parameter logic [ADDR_W-1:0]   BASE   = 9'h100,
  localparam int unsigned        IDX_W  = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              hit,
  output logic              is_ctrl,
  output logic [IDX_W-1:0]  idx,
  output logic [N_TMR-1:0]  reload_we,
  output logic [N_TMR-1:0]  ctrl_we
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * N_TMR);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off     = addr - BASE;
    hit     = (addr >= BASE) && (off < SPAN) && !off[0];
    is_ctrl = off[1];
    idx     = off[IDX_W+1:2];
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_we
    assign reload_we[g] = we && hit && !is_ctrl && (idx == IDX_W'(g));
    assign ctrl_we[g]   = we && hit &&  is_ctrl && (idx == IDX_W'(g));
  end

  assert_single_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reload_we, ctrl_we}));
endmodule

// File: rtl/quad_reload_timer.sv
module quad_reload_timer #(
  parameter int unsigned       N_TMR  = 4,
  parameter int unsigned       CNT_W  = 16,
  parameter int unsigned       PRE_W  = 10,
  parameter int unsigned       ADDR_W = 9,
  parameter logic [ADDR_W-1:0] BASE   = 9'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic [N_TMR-1:0]  ovf_o,
  output logic [N_TMR-1:0]  irq_o
);
  import tmr_pkg::*;

  localparam int unsigned IDX_W = (N_TMR > 1) ? $clog2(N_TMR) : 1;

  logic             hit;
  logic             is_ctrl;
  logic [IDX_W-1:0] idx;
  logic [N_TMR-1:0] reload_we;
  logic [N_TMR-1:0] ctrl_we;
  logic [N_TMR-1:0] chain_in;
  logic [CNT_W-1:0] count_arr [N_TMR];
  tmr_ctrl_t        ctrl_arr  [N_TMR];

  tmr_bus_decode #(.N_TMR(N_TMR), .ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (bus_addr),
    .we        (bus_we),
    .hit       (hit),
    .is_ctrl   (is_ctrl),
    .idx       (idx),
    .reload_we (reload_we),
    .ctrl_we   (ctrl_we)
  );

  // channel 0 has no lower neighbour: its chain input is tied low
  assign chain_in[0] = 1'b0;
  for (genvar g = 1; g < N_TMR; g++) begin : g_chain
    assign chain_in[g] = ovf_o[g-1];
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (ctrl_we[g]),
      .reload_we (reload_we[g]),
      .wdata     (bus_wdata),
      .chain_in  (chain_in[g]),
      .count_o   (count_arr[g]),
      .ctrl_o    (ctrl_arr[g]),
      .ovf_o     (ovf_o[g]),
      .irq_o     (irq_o[g])
    );
  end

  for (genvar g = 1; g < N_TMR; g++) begin : g_chk
    assert_chain_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_arr[g].run && src_is_chain(ctrl_arr[g].src) && !ovf_o[g-1] && !ctrl_we[g])
        |=> $stable(count_arr[g]));
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      if (is_ctrl) bus_rdata = ctrl_to_bus(ctrl_arr[idx]);
      else         bus_rdata = BUS_W'(count_arr[idx]);
    end
  end

  assert_ch0_chain_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    src_is_chain(ctrl_arr[0].src) |-> !ovf_o[0]);
endmodule

// File: tb/quad_reload_timer_tb_top.sv
module quad_reload_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  ovf_o;
  logic [3:0]  irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  quad_reload_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ovf_o     (ovf_o),
    .irq_o     (irq_o)
  );

  function automatic logic [8:0] cnt_a(input int n); return 9'h100 + 9'(4 * n); endfunction
  function automatic logic [8:0] ctl_a(input int n); return 9'h102 + 9'(4 * n); endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    #1;
  endtask

  task automatic peek(input logic [8:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int i = 0; i < 4; i++) begin
      peek(cnt_a(i), v); chk("R1 count after reset", v, 16'h0000);
      peek(ctl_a(i), v); chk("R1 control after reset", v, 16'h0000);
    end
    chk("R1 strobes after reset", {8'h00, ovf_o, irq_o}, 16'h0000);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    bus_write(ctl_a(1), 16'hFF7C);
    peek(ctl_a(1), v); chk("R2 control read masking", v, 16'h0044);
    bus_write(ctl_a(1), 16'h0000);
    bus_write(cnt_a(0), 16'h1234);
    peek(cnt_a(0), v); chk("R3 reload write leaves count", v, 16'h0000);
    peek(9'h0FE, v); chk("R11 below map reads 0", v, 16'h0000);
    peek(9'h110, v); chk("R11 above map reads 0", v, 16'h0000);
    peek(9'h101, v); chk("R11 odd offset reads 0", v, 16'h0000);
    bus_write(cnt_a(3), 16'h2222);
    bus_write(ctl_a(3), 16'h0080);
    peek(cnt_a(3), v); chk("R11 channel 3 reload at 0x10C", v, 16'h2222);
    bus_write(ctl_a(3), 16'h0000);
  endtask

  task automatic t_count_wrap;
    logic [15:0] v;
    logic [15:0] frozen;
    bus_write(cnt_a(0), 16'hFFF0);
    bus_write(ctl_a(0), 16'h0080);
    peek(cnt_a(0), v); chk("R4 enable loads reload", v, 16'hFFF0);
    idle(1); peek(cnt_a(0), v); chk("R5 step every clock", v, 16'hFFF1);
    idle(13); peek(cnt_a(0), v); chk("R5 count before wrap", v, 16'hFFFE);
    chk("R7 no strobe before wrap", {12'h000, ovf_o}, 16'h0000);
    idle(1); peek(cnt_a(0), v); chk("R7 count at top", v, 16'hFFFF);
    chk("R7 overflow strobe", {12'h000, ovf_o}, 16'h0001);
    chk("R8 no irq when disabled", {12'h000, irq_o}, 16'h0000);
    idle(1); peek(cnt_a(0), v); chk("R7 reload after wrap", v, 16'hFFF0);
    chk("R7 strobe one cycle", {12'h000, ovf_o}, 16'h0000);
    bus_write(ctl_a(0), 16'h0000);
    peek(cnt_a(0), frozen);
    idle(20); peek(cnt_a(0), v); chk("R10 stopped count frozen", v, frozen);
    bus_write(cnt_a(0), 16'hABCD);
    peek(cnt_a(0), v); chk("R3 reload write does not touch count", v, frozen);
    bus_write(ctl_a(0), 16'h0080);
    peek(cnt_a(0), v); chk("R3 stored reload used on enable", v, 16'hABCD);
    bus_write(ctl_a(0), 16'h0000);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    bus_write(cnt_a(0), 16'hFFFE);
    bus_write(ctl_a(0), 16'h00C0);
    chk("R8 irq low before wrap", {12'h000, irq_o}, 16'h0000);
    idle(1);
    chk("R8 irq with overflow", {12'h000, irq_o}, 16'h0001);
    chk("R8 overflow alongside irq", {12'h000, ovf_o}, 16'h0001);
    idle(1); peek(cnt_a(0), v);
    chk("R8 irq one cycle", {12'h000, irq_o}, 16'h0000);
    chk("R7 reload after irq wrap", v, 16'hFFFE);
    bus_write(ctl_a(0), 16'h0000);
  endtask

  task automatic t_prescale;
    logic [15:0] v;
    bus_write(cnt_a(2), 16'h0000);
    bus_write(ctl_a(2), 16'h0081);
    idle(63); peek(cnt_a(2), v); chk("R6 div64 no step before period", v, 16'h0000);
    idle(1);  peek(cnt_a(2), v); chk("R6 div64 first step", v, 16'h0001);
    idle(64); peek(cnt_a(2), v); chk("R6 div64 second step", v, 16'h0002);
    bus_write(ctl_a(2), 16'h0000);
    bus_write(ctl_a(2), 16'h0082);
    peek(cnt_a(2), v); chk("R4 re-enable reloads", v, 16'h0000);
    idle(255); peek(cnt_a(2), v); chk("R6 div256 no step before period", v, 16'h0000);
    idle(1);   peek(cnt_a(2), v); chk("R6 div256 first step", v, 16'h0001);
    bus_write(ctl_a(2), 16'h0000);
    bus_write(ctl_a(2), 16'h0083);
    idle(1023); peek(cnt_a(2), v); chk("R6 div1024 no step before period", v, 16'h0000);
    idle(1);    peek(cnt_a(2), v); chk("R6 div1024 first step", v, 16'h0001);
    bus_write(ctl_a(2), 16'h0000);
  endtask

  task automatic t_chain;
    logic [15:0] v;
    logic [15:0] held;
    bus_write(cnt_a(1), 16'h0010);
    bus_write(ctl_a(1), 16'h0087);
    bus_write(cnt_a(0), 16'hFFFE);
    bus_write(ctl_a(0), 16'h0080);
    peek(cnt_a(1), v); chk("R9 chained count before overflow", v, 16'h0010);
    idle(2); peek(cnt_a(1), v); chk("R9 chained step on overflow", v, 16'h0011);
    idle(8); peek(cnt_a(1), v); chk("R9 chained steps follow overflows", v, 16'h0015);
    bus_write(ctl_a(0), 16'h0000);
    peek(cnt_a(1), held);
    idle(10); peek(cnt_a(1), v); chk("R10 chained hold with lower stopped", v, held);
    chk("R10 no overflow while stopped", {12'h000, ovf_o}, 16'h0000);
    bus_write(ctl_a(0), 16'h0080);
    peek(cnt_a(1), v); chk("R10 resume without reload", v, held);
    idle(2); peek(cnt_a(1), v); chk("R10 resume continues count", v, held + 16'h0001);
    bus_write(ctl_a(0), 16'h0000);
    bus_write(ctl_a(1), 16'h0000);
    bus_write(cnt_a(0), 16'h0005);
    bus_write(ctl_a(0), 16'h0084);
    idle(20); peek(cnt_a(0), v); chk("R9 channel 0 idle in chain mode", v, 16'h0005);
    chk("R9 channel 0 no overflow in chain mode", {12'h000, ovf_o}, 16'h0000);
    bus_write(ctl_a(0), 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_regs();
    t_count_wrap();
    t_irq();
    t_prescale();
    t_chain();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule